// File: doc/BRIEF.md
# Pixel Stipple and Fill/Copy Engine

This block draws into an 8-bit-per-pixel frame memory on behalf of a bus master. Every command is a pair of 32-bit bus writes. A write with bus address bit 2 clear only stores its data as the drawing colour. A write with bus address bit 2 set starts an operation. The destination pixel comes from the bus address of that write, and the written data selects what is drawn. A window-select input chooses between two operations. The stipple window paints the colour through a 32-bit mask. The blit window either fills a run of pixels with the colour or copies a run from a source pixel address.

The engine owns a single-port frame memory port with address, write data, write enable and registered read data (one cycle of read latency). It takes one memory step per cycle. A fill pixel and a stipple bit each take one step. A copied pixel takes two steps, a read and then a write. While an operation runs, `busy` is high and the bus is stalled by holding `bus_ready` low. A one-cycle `done` pulse marks completion. Reads of either window return zero and have no side effects.

Top module: `pixel_fill_engine`

## Requirements
- R1: After reset `busy` and `done` are 0, `bus_ready` is 1 and `mem_we` is 0.
- R2: An accepted write with bus address bit 2 = 0 stores only bits 7:0 of its data as the colour. It starts no operation and writes no memory.
- R3: An accepted write with bus address bit 2 = 1 starts an operation. Its destination pixel is bus address bits PIX_AW+2:3, that is, the address shifted right by 3 and reduced modulo 2^PIX_AW.
- R4: When `bus_blit` = 0 (stipple), the trigger data is a mask. Bit 31 maps to destination+0 and bit 0 to destination+31. Pixels for set bits receive the colour and pixels for clear bits are left unchanged. The operation is busy for exactly 32 cycles.
- R5: When `bus_blit` = 1, the trigger data bits 23:0 give the source pixel address and bits 28:24 plus one give the length, from 1 to 32. Bits 31:29 have no effect.
- R6: In blit mode a source field of 0xFFFFFF means fill. The colour is written to destination+0 through destination+length-1, and the operation is busy for exactly length cycles.
- R7: In blit mode any other source value means copy. For k = 0 up to length-1, in ascending order, pixel source+k is read and then written to destination+k. An overlapping copy therefore sees its own earlier writes. The operation is busy for exactly 2*length cycles.
- R8: `bus_ready` is 0 while `busy` is 1, and no write of either kind is taken during that time. A write held off in this way is taken once the engine is idle.
- R9: `done` is high for exactly one cycle: the first cycle with `busy` low after an operation.
- R10: Bus reads return zero on `bus_rdata` and start no operation.
- R11: Pixel addresses wrap modulo 2^PIX_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_blit | input | 1 | Window select: 0 = stipple, 1 = fill/copy |
| bus_addr | input | PIX_AW+3 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access taken on this edge when high |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | PIX_AW | Frame memory pixel address |
| mem_wdata | output | PIX_W | Frame memory write data |
| mem_we | output | 1 | Frame memory write enable |
| mem_rdata | input | PIX_W | Frame memory read data, one cycle after address |

## Verification
The trigger is taken on edge E0. `busy` is then high for 32, length or 2*length cycles, and `done` goes high in the next cycle and low one cycle after that. The bench samples at falling edges, so it counts exactly the cycles in which `busy` is high. It checks `done` at the first falling edge with `busy` low and again at the one after. Frame memory contents are compared only after `busy` has dropped, because the last memory write lands on the same edge that clears `busy`. The hold-off test checks `bus_ready` at the falling edge right after the trigger, and then checks that the pending colour write waits for the end of the running operation.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
   typedef enum logic [1:0] {
      OP_STIP = 2'd0,
      OP_FILL = 2'd1,
      OP_COPY = 2'd2
   } op_e;

   localparam int          MASK_W   = 32;
   localparam int          LEN_W    = 5;
   localparam int          SRC_W    = 24;
   localparam logic [23:0] FILL_KEY = 24'hFFFFFF;
endpackage

// File: rtl/pfe_decode.sv
module pfe_decode
   import pfe_pkg::*;
#(
   parameter int PIX_AW = 20,
   parameter int PIX_W  = 8
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic              bus_blit,
   input  logic [PIX_AW+2:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              eng_busy,
   output logic              latch_stb,
   output logic              start_stb,
   output op_e               start_op,
   output logic [PIX_AW-1:0] start_dst,
   output logic [PIX_AW-1:0] start_src,
   output logic [LEN_W-1:0]  start_len_m1,
   output logic [MASK_W-1:0] start_mask,
   output logic [PIX_W-1:0]  latch_colour
);
   logic take;
   logic unused_bits;

   // writes are only taken while idle
   assign take         = bus_valid && bus_write && !eng_busy;
   assign latch_stb    = take && !bus_addr[2];
   assign start_stb    = take && bus_addr[2];
   assign start_dst    = bus_addr[PIX_AW+2:3];
   assign start_src    = bus_wdata[PIX_AW-1:0];
   assign start_len_m1 = bus_wdata[SRC_W+LEN_W-1:SRC_W];
   assign start_mask   = bus_wdata;
   assign latch_colour = bus_wdata[PIX_W-1:0];
   assign unused_bits  = ^bus_addr[1:0];

   always_comb begin
      if (!bus_blit)
         start_op = OP_STIP;
      else if (bus_wdata[SRC_W-1:0] == FILL_KEY)
         start_op = OP_FILL;
      else
         start_op = OP_COPY;
   end
endmodule

// File: rtl/pfe_seq.sv
module pfe_seq
   import pfe_pkg::*;
#(
   parameter int PIX_AW = 20,
   parameter int PIX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_stb,
   input  logic              start_stb,
   input  op_e               start_op,
   input  logic [PIX_AW-1:0] start_dst,
   input  logic [PIX_AW-1:0] start_src,
   input  logic [LEN_W-1:0]  start_len_m1,
   input  logic [MASK_W-1:0] start_mask,
   input  logic [PIX_W-1:0]  latch_colour,
   output logic              busy,
   output logic              done,
   output op_e               cur_op,
   output logic [PIX_AW-1:0] cur_dst,
   output logic [PIX_AW-1:0] cur_src,
   output logic [LEN_W-1:0]  cur_step,
   output logic              cur_phase,
   output logic              cur_bit,
   output logic [PIX_W-1:0]  colour
);
   localparam logic [LEN_W-1:0] STIP_LAST = LEN_W'(MASK_W - 1);

   logic [LEN_W-1:0]  len_m1;
   logic [MASK_W-1:0] mask;
   logic              step_end;
   logic              last_step;

   assign cur_bit   = mask[MASK_W-1];
   // a copy step ends on its write phase, other steps take one cycle
   assign step_end  = busy && ((cur_op != OP_COPY) || cur_phase);
   assign last_step = (cur_op == OP_STIP) ? (cur_step == STIP_LAST)
                                          : (cur_step == len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         cur_op    <= OP_STIP;
         cur_dst   <= '0;
         cur_src   <= '0;
         cur_step  <= '0;
         cur_phase <= 1'b0;
         len_m1    <= '0;
         mask      <= '0;
         colour    <= '0;
      end else begin
         done <= 1'b0;
         if (latch_stb)
            colour <= latch_colour;
         if (start_stb) begin
            busy      <= 1'b1;
            cur_op    <= start_op;
            cur_dst   <= start_dst;
            cur_src   <= start_src;
            cur_step  <= '0;
            cur_phase <= 1'b0;
            len_m1    <= start_len_m1;
            mask      <= start_mask;
         end else if (busy) begin
            if (cur_op == OP_COPY)
               cur_phase <= !cur_phase;
            if (step_end) begin
               if (last_step) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  cur_step <= cur_step + LEN_W'(1);
                  mask     <= {mask[MASK_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   // R8: a new operation is only started from idle
   a_r8_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |-> !busy);
   // R2: storing the colour never starts an operation
   a_r2_latch_no_op: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |=> !busy);
   // R9: done follows the fall of busy
   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R9: done lasts a single cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/pfe_memport.sv
module pfe_memport
   import pfe_pkg::*;
#(
   parameter int PIX_AW = 20,
   parameter int PIX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  op_e               cur_op,
   input  logic [PIX_AW-1:0] cur_dst,
   input  logic [PIX_AW-1:0] cur_src,
   input  logic [LEN_W-1:0]  cur_step,
   input  logic              cur_phase,
   input  logic              cur_bit,
   input  logic [PIX_W-1:0]  colour,
   input  logic [PIX_W-1:0]  mem_rdata,
   output logic [PIX_AW-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_wdata,
   output logic              mem_we
);
   logic [PIX_AW-1:0] offs;
   logic              is_read;

   assign offs    = PIX_AW'(cur_step);
   assign is_read = (cur_op == OP_COPY) && !cur_phase;

   // additions wrap modulo 2^PIX_AW (R11)
   assign mem_addr  = is_read ? (cur_src + offs) : (cur_dst + offs);
   assign mem_wdata = (cur_op == OP_COPY) ? mem_rdata : colour;

   always_comb begin
      unique case (cur_op)
         OP_STIP: mem_we = busy && cur_bit;
         OP_FILL: mem_we = busy;
         OP_COPY: mem_we = busy && cur_phase;
         default: mem_we = 1'b0;
      endcase
   end

   // R4: memory is only written while an operation runs
   a_r4_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   // R7: every copy write is preceded by a read cycle
   a_r7_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && cur_op == OP_COPY) |-> $past(busy && !mem_we));
endmodule

// File: rtl/pixel_fill_engine.sv
module pixel_fill_engine
   import pfe_pkg::*;
#(
   parameter int PIX_AW = 20,
   parameter int PIX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic              bus_blit,
   input  logic [PIX_AW+2:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ready,
   output logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              done,
   output logic [PIX_AW-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_wdata,
   output logic              mem_we,
   input  logic [PIX_W-1:0]  mem_rdata
);
   if (PIX_AW < LEN_W || PIX_AW > SRC_W) begin : g_bad_aw
      $error("pixel_fill_engine: PIX_AW out of range");
   end
   if (PIX_W < 1 || PIX_W > 32) begin : g_bad_pw
      $error("pixel_fill_engine: PIX_W out of range");
   end

   logic              latch_stb, start_stb;
   op_e               start_op, cur_op;
   logic [PIX_AW-1:0] start_dst, start_src, cur_dst, cur_src;
   logic [LEN_W-1:0]  start_len_m1, cur_step;
   logic [MASK_W-1:0] start_mask;
   logic [PIX_W-1:0]  latch_colour, colour;
   logic              cur_phase, cur_bit;

   assign bus_ready = !busy;
   assign bus_rdata = '0;

   pfe_decode #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) u_dec (
      .bus_valid    (bus_valid),
      .bus_write    (bus_write),
      .bus_blit     (bus_blit),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .eng_busy     (busy),
      .latch_stb    (latch_stb),
      .start_stb    (start_stb),
      .start_op     (start_op),
      .start_dst    (start_dst),
      .start_src    (start_src),
      .start_len_m1 (start_len_m1),
      .start_mask   (start_mask),
      .latch_colour (latch_colour)
   );

   pfe_seq #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_stb    (latch_stb),
      .start_stb    (start_stb),
      .start_op     (start_op),
      .start_dst    (start_dst),
      .start_src    (start_src),
      .start_len_m1 (start_len_m1),
      .start_mask   (start_mask),
      .latch_colour (latch_colour),
      .busy         (busy),
      .done         (done),
      .cur_op       (cur_op),
      .cur_dst      (cur_dst),
      .cur_src      (cur_src),
      .cur_step     (cur_step),
      .cur_phase    (cur_phase),
      .cur_bit      (cur_bit),
      .colour       (colour)
   );

   pfe_memport #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .cur_op    (cur_op),
      .cur_dst   (cur_dst),
      .cur_src   (cur_src),
      .cur_step  (cur_step),
      .cur_phase (cur_phase),
      .cur_bit   (cur_bit),
      .colour    (colour),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we)
   );

   // R10: reads never start work
   a_r10_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && !busy) |=> !busy);
endmodule

// File: tb/sim_pixel_fill_engine.sv
module sim_pixel_fill_engine;
   localparam int AW  = 10;
   localparam int NPX = 1 << AW;
   localparam int BAW = AW + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_valid = 1'b0, bus_write = 1'b0, bus_blit = 1'b0;
   logic [BAW-1:0] bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic           bus_ready, busy, done, mem_we;
   logic [31:0]    bus_rdata;
   logic [AW-1:0]  mem_addr;
   logic [7:0]     mem_wdata, mem_rdata;

   logic [7:0] fb    [NPX];
   logic [7:0] ref_m [NPX];
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pixel_fill_engine #(.PIX_AW(AW), .PIX_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_blit(bus_blit), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .busy(busy), .done(done),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata));

   always @(posedge clk) begin
      mem_rdata <= fb[mem_addr];
      if (mem_we) fb[mem_addr] <= mem_wdata;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cmp_mem(input string req);
      int bad_i = -1;
      for (int i = 0; i < NPX; i++)
         if (bad_i < 0 && fb[i] !== ref_m[i]) bad_i = i;
      if (bad_i < 0) check(1, req, 0, 0);
      else check(0, {req, " pixel mismatch"}, int'(fb[bad_i]), int'(ref_m[bad_i]));
   endtask

   task automatic bus_wr(input logic blit, input int a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_blit = blit;
      bus_addr = BAW'(a); bus_wdata = d;
      while (!bus_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic wait_op(input int exp_cyc, input string req);
      int n = 0;
      while (busy && n < 200) begin n++; @(negedge clk); end
      check(n == exp_cyc, {req, " busy cycles"}, n, exp_cyc);
      check(done == 1'b1, "R9 done high after busy", int'(done), 1);
      @(negedge clk);
      check(done == 1'b0, "R9 done single cycle", int'(done), 0);
   endtask

   function automatic void ref_stip(input int dst, input logic [31:0] m, input logic [7:0] c);
      for (int i = 0; i < 32; i++)
         if (m[31-i]) ref_m[(dst + i) % NPX] = c;
   endfunction

   function automatic void ref_fill(input int dst, input int len, input logic [7:0] c);
      for (int i = 0; i < len; i++) ref_m[(dst + i) % NPX] = c;
   endfunction

   function automatic void ref_copy(input int dst, input int src, input int len);
      for (int i = 0; i < len; i++) ref_m[(dst + i) % NPX] = ref_m[(src + i) % NPX];
   endfunction

   function automatic logic [31:0] bl(input int len, input int src);
      return {3'b000, 5'(len - 1), 24'(src)};
   endfunction

   task automatic t_reset;
      check(busy == 0, "R1 busy", int'(busy), 0);
      check(bus_ready == 1, "R1 ready", int'(bus_ready), 1);
      check(done == 0, "R1 done", int'(done), 0);
      check(mem_we == 0, "R1 we", int'(mem_we), 0);
   endtask

   task automatic t_stipple;
      bus_wr(0, 0, 32'h1234_5678);
      check(busy == 0, "R2 latch starts nothing", int'(busy), 0);
      cmp_mem("R2 latch leaves memory");
      bus_wr(0, (100 << 3) | 4, 32'hA000_0001);
      ref_stip(100, 32'hA000_0001, 8'h78);
      wait_op(32, "R4 stipple");
      cmp_mem("R4 R3 stipple pixels");
      bus_wr(0, (400 << 3) | 4, 32'h0);
      wait_op(32, "R4 empty mask");
      cmp_mem("R4 empty mask leaves memory");
   endtask

   task automatic t_fill;
      bus_wr(1, 0, 32'hABCD_EF5A);
      bus_wr(1, (200 << 3) | 4, bl(10, 24'hFFFFFF));
      ref_fill(200, 10, 8'h5A);
      wait_op(10, "R6 fill");
      cmp_mem("R6 fill pixels");
      bus_wr(1, (600 << 3) | 4, 32'hFFFF_FFFF);
      ref_fill(600, 32, 8'h5A);
      wait_op(32, "R5 max length");
      cmp_mem("R5 length 32 upper bits ignored");
   endtask

   task automatic t_copy;
      bus_wr(1, (500 << 3) | 4, bl(6, 300));
      ref_copy(500, 300, 6);
      wait_op(12, "R7 copy");
      cmp_mem("R7 copy pixels");
      bus_wr(1, (701 << 3) | 4, bl(4, 700));
      ref_copy(701, 700, 4);
      wait_op(8, "R7 overlap copy");
      cmp_mem("R7 overlap ascending");
      bus_wr(1, (50 << 3) | 4, bl(1, 51));
      ref_copy(50, 51, 1);
      wait_op(2, "R5 length 1 copy");
      cmp_mem("R5 length 1 copy pixels");
   endtask

   task automatic t_wrap;
      bus_wr(0, 0, 32'h0000_00C3);
      bus_wr(0, (1020 << 3) | 4, 32'hFFFF_FFFF);
      ref_stip(1020, 32'hFFFF_FFFF, 8'hC3);
      wait_op(32, "R11 wrap stipple");
      cmp_mem("R11 wrap pixels");
   endtask

   task automatic t_holdoff;
      bus_wr(0, (800 << 3) | 4, 32'hFFFF_0000);
      ref_stip(800, 32'hFFFF_0000, 8'hC3);
      bus_valid = 1; bus_write = 1; bus_blit = 1;
      bus_addr = '0; bus_wdata = 32'h0000_0011;
      check(bus_ready == 0, "R8 ready low while busy", int'(bus_ready), 0);
      while (!bus_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
      bus_valid = 0; bus_write = 0;
      cmp_mem("R8 running op kept old colour");
      bus_wr(1, (40 << 3) | 4, bl(3, 24'hFFFFFF));
      ref_fill(40, 3, 8'h11);
      wait_op(3, "R8 held write taken");
      cmp_mem("R8 held colour used");
   endtask

   task automatic t_read;
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_blit = 1;
      bus_addr = BAW'((10 << 3) | 4); bus_wdata = bl(5, 24'hFFFFFF);
      check(bus_rdata == 0, "R10 read data zero", int'(bus_rdata), 0);
      @(posedge clk); @(negedge clk);
      bus_valid = 0;
      check(busy == 0, "R10 read starts nothing", int'(busy), 0);
      cmp_mem("R10 read leaves memory");
   endtask

   initial begin
      for (int i = 0; i < NPX; i++) begin
         fb[i] = 8'(i * 7 + 3);
         ref_m[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_stipple();
      t_fill();
      t_copy();
      t_wrap();
      t_holdoff();
      t_read();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule